// File: doc/BRIEF.md
# Reset Cause Status Register Bank

This block is the software-visible register bank of a reset controller. It records which reset source fired since the last hardware reset in a set of sticky cause flags. It also holds the control settings that decide whether each source's pulse is passed on as a reset request. A simple single-cycle register bus reaches two registers, a status register and a control register. Writes take effect at the clock edge. Reads are combinational while the bus is selected with the write strobe low.

The status register holds one cause flag per source, cleared by writing 1, next to a plain read/write warm-boot indication bit. The control register holds these fields:
- a 4-bit keyed mask code for the watchdog source;
- a 4-bit keyed mask code for the temperature-sensor source;
- two self-clearing software reset command bits, one for a core reset and one for a core debug reset;
- an enable bit for lockup resets;
- an enable bit for warm resets.

The block has one event input per source and one completion pulse input per command bit. It drives the gated per-source reset requests, the command levels and the warm-reset enable to the reset sequencer.

Top module: `rst_cause_regs`

## Requirements
- R1: After hardware reset the status register (address 0) reads 0. The control register (address 1) reads 0x0000202A: watchdog key 0xA in bits [3:0], temperature key 0x2 in bits [7:4], both command bits (8 = core, 9 = core debug) 0, lockup enable (bit 12) 0 and warm enable (bit 13) 1. No request or command output is active.
- R2: The sources map to status bits 0 power-on, 1 reset pin, 2 watchdog, 3 JTAG-generated, 4 JTAG software, 5 temperature sensor, 6 core lockup and 7 software request. An event pulse sets its flag at the next edge, and the flag stays set with no further events.
- R3: A status write clears each flag whose bit in the write data is 1. Flags whose bit is 0 are unchanged.
- R4: When a source event and a clearing write to the same flag occur in the same cycle, the flag ends up set.
- R5: Status bit 16 is a read/write warm-boot bit. A status write loads it from the write data, and flag bits written 0 are left intact.
- R6: The watchdog event is passed to rstReq[2] in the same cycle unless the watchdog key equals 0x5. Any other key value, including the default 0xA and undefined codes, leaves it unmasked.
- R7: The temperature event is passed to rstReq[5] unless the temperature key equals 0x5. The codes 0x2 and any other value leave it unmasked.
- R8: A watchdog event while masked sets flag 2 but raises no request. From then on, writing 1 to bit 2 no longer clears it; only hardware reset does.
- R9: The lockup event reaches rstReq[6] only while lockup enable is 1.
- R10: Writing 1 to control bit 8 or 9 sets the matching swRstCmd bit, and writing 0 there has no effect. A pulse on the matching cmdDone bit clears it, and when the setting write and the completion pulse coincide the write wins.
- R11: Sources 0, 1, 3, 4 and 7 are always passed to rstReq in the same cycle, whatever the control settings.
- R12: Bus addresses other than 0 and 1 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| srcEvt | input | 8 | One pulse per reset source, bit order as in R2 |
| cmdDone | input | 2 | Completion pulse per command bit (0 core, 1 core debug) |
| rstReq | output | 8 | Per-source reset requests after gating |
| swRstCmd | output | 2 | Software reset command levels |
| warmRstEn | output | 1 | Warm reset enable level |

## Verification
The bench builds the block with its default ADDR_W of 4 and DATA_W of 32. The 4-bit address space leaves fourteen unmapped addresses for R12 writes and reads. The 32-bit data width holds every field at the bit positions the requirements name. Random key writes draw from the masked code, the defined unmasked codes and arbitrary 4-bit values, so undefined codes are exercised. A second hardware reset mid-run shows that a locked watchdog flag clears only that way.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int SRC_W = 8;
  localparam int NUM_CMD = 2;
  localparam int KEY_W = 4;

  localparam int SRC_WDOG = 2;
  localparam int SRC_TEMP = 5;
  localparam int SRC_LOCKUP = 6;

  localparam logic [KEY_W-1:0] KEY_MASKED = 4'h5;
  localparam logic [KEY_W-1:0] WDOG_KEY_DEF = 4'hA;
  localparam logic [KEY_W-1:0] TEMP_KEY_DEF = 4'h2;

  localparam int WARM_BIT = 16;
  localparam int WKEY_LSB = 0;
  localparam int TKEY_LSB = 4;
  localparam int CMD_LSB = 8;
  localparam int LOCKEN_BIT = 12;
  localparam int WARMEN_BIT = 13;

  localparam int STATUS_ADDR = 0;
  localparam int CTRL_ADDR = 1;

  typedef struct packed {
    logic statusWr;
    logic ctrlWr;
    logic statusRd;
    logic ctrlRd;
  } busStrobes_t;
endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobes_t       strb
);
  logic hitStatus, hitCtrl;

  always_comb begin
    hitStatus = (busAddr == ADDR_W'(STATUS_ADDR));
    hitCtrl   = (busAddr == ADDR_W'(CTRL_ADDR));
    strb.statusWr = busSel && busWr && hitStatus;
    strb.ctrlWr   = busSel && busWr && hitCtrl;
    strb.statusRd = busSel && !busWr && hitStatus;
    strb.ctrlRd   = busSel && !busWr && hitCtrl;
  end

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.statusWr, strb.ctrlWr, strb.statusRd, strb.ctrlRd}));
endmodule

// File: rtl/rcr_datapath.sv
module rcr_datapath
  import rcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  busStrobes_t        strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [SRC_W-1:0]   srcEvt,
  input  logic [NUM_CMD-1:0] cmdDone,
  output logic [SRC_W-1:0]   rstReq,
  output logic [NUM_CMD-1:0] swRstCmd,
  output logic               warmRstEn
);
  logic [SRC_W-1:0]   flags, clrMask, lockMask, gateVec;
  logic               warmBoot, wdogLock, lockupEn, warmEn;
  logic [KEY_W-1:0]   wdogKey, tempKey;
  logic [NUM_CMD-1:0] cmdBits, cmdSet;
  logic               wdogMasked, tempMasked;

  always_comb begin
    wdogMasked = (wdogKey == KEY_MASKED);
    tempMasked = (tempKey == KEY_MASKED);
    lockMask = '0;
    lockMask[SRC_WDOG] = wdogLock;
    clrMask = strb.statusWr ? (wdata[SRC_W-1:0] & ~lockMask) : '0;
    gateVec = '1;
    gateVec[SRC_WDOG] = !wdogMasked;
    gateVec[SRC_TEMP] = !tempMasked;
    gateVec[SRC_LOCKUP] = lockupEn;
    rstReq = srcEvt & gateVec;
  end

  generate
    for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
      assign cmdSet[i] = strb.ctrlWr && wdata[CMD_LSB+i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmdBits[i] <= 1'b0;
        else if (cmdSet[i]) cmdBits[i] <= 1'b1;
        else if (cmdDone[i]) cmdBits[i] <= 1'b0;
      end
      // R10
      cmd_clear_by_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmdBits[i]) |-> $past(cmdDone[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      warmBoot <= 1'b0;
      wdogLock <= 1'b0;
      wdogKey  <= WDOG_KEY_DEF;
      tempKey  <= TEMP_KEY_DEF;
      lockupEn <= 1'b0;
      warmEn   <= 1'b1;
    end else begin
      flags <= (flags & ~clrMask) | srcEvt;
      if (srcEvt[SRC_WDOG] && wdogMasked) wdogLock <= 1'b1;
      if (strb.statusWr) warmBoot <= wdata[WARM_BIT];
      if (strb.ctrlWr) begin
        wdogKey  <= wdata[WKEY_LSB +: KEY_W];
        tempKey  <= wdata[TKEY_LSB +: KEY_W];
        lockupEn <= wdata[LOCKEN_BIT];
        warmEn   <= wdata[WARMEN_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.statusRd) begin
      rdata[SRC_W-1:0] = flags;
      rdata[WARM_BIT]  = warmBoot;
    end
    if (strb.ctrlRd) begin
      rdata[WKEY_LSB +: KEY_W]  = wdogKey;
      rdata[TKEY_LSB +: KEY_W]  = tempKey;
      rdata[CMD_LSB +: NUM_CMD] = cmdBits;
      rdata[LOCKEN_BIT] = lockupEn;
      rdata[WARMEN_BIT] = warmEn;
    end
  end

  assign swRstCmd  = cmdBits;
  assign warmRstEn = warmEn;

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcEvt != '0) |=> ((flags & $past(srcEvt)) == $past(srcEvt)));
  // R3
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != '0) |-> $past(strb.statusWr));
  // R8
  wdog_lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdogLock |-> flags[SRC_WDOG]);
  // R5
  warm_bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warmBoot) |-> $past(strb.statusWr));
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [SRC_W-1:0]   srcEvt,
  input  logic [NUM_CMD-1:0] cmdDone,
  output logic [SRC_W-1:0]   rstReq,
  output logic [NUM_CMD-1:0] swRstCmd,
  output logic               warmRstEn
);
  busStrobes_t strb;

  rcr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strb(strb)
  );

  rcr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .srcEvt(srcEvt), .cmdDone(cmdDone), .rstReq(rstReq),
    .swRstCmd(swRstCmd), .warmRstEn(warmRstEn)
  );

  // R11
  req_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rstReq & ~srcEvt) == '0));
endmodule

// File: tb/rst_cause_regs_bench.sv
module rst_cause_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busSel = 0, busWr = 0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [7:0] srcEvt = '0, rstReq;
  logic [1:0] cmdDone = '0, swRstCmd;
  logic warmRstEn;
  int total = 0, bad = 0;

  logic [7:0] mFlags;
  logic mWarm, mWlock, mCore, mDbg, mLock, mWen;
  logic [3:0] mWkey, mTkey;

  always #5 clk = ~clk;

  rst_cause_regs u_rst_cause_regs (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcEvt(srcEvt), .cmdDone(cmdDone),
    .rstReq(rstReq), .swRstCmd(swRstCmd), .warmRstEn(warmRstEn)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mFlags = '0; mWarm = 0; mWlock = 0; mCore = 0; mDbg = 0;
    mLock = 0; mWen = 1; mWkey = 4'hA; mTkey = 4'h2;
  endtask

  function automatic logic [7:0] expReq(logic [7:0] evt);
    logic [7:0] g = '1;
    g[2] = (mWkey != 4'h5);
    g[5] = (mTkey != 4'h5);
    g[6] = mLock;
    return evt & g;
  endfunction

  function automatic logic [31:0] expStatus();
    logic [31:0] v = '0;
    v[7:0] = mFlags; v[16] = mWarm;
    return v;
  endfunction

  function automatic logic [31:0] expCtrl();
    logic [31:0] v = '0;
    v[3:0] = mWkey; v[7:4] = mTkey; v[8] = mCore; v[9] = mDbg;
    v[12] = mLock; v[13] = mWen;
    return v;
  endfunction

  task automatic step(string tag, logic [7:0] evt, logic [1:0] done,
                      logic wr, logic [3:0] addr, logic [31:0] wd);
    logic [7:0] clr;
    @(negedge clk);
    srcEvt = evt; cmdDone = done; busSel = wr; busWr = wr; busAddr = addr; busWdata = wd;
    #1 chk(tag, {24'b0, rstReq}, {24'b0, expReq(evt)});
    @(posedge clk);
    clr = (wr && addr == 0) ? (wd[7:0] & ~{5'b0, mWlock, 2'b0}) : 8'h00;
    if (evt[2] && mWkey == 4'h5) mWlock = 1;
    mFlags = (mFlags & ~clr) | evt;
    if (wr && addr == 0) mWarm = wd[16];
    mCore = (wr && addr == 1 && wd[8]) ? 1'b1 : (done[0] ? 1'b0 : mCore);
    mDbg  = (wr && addr == 1 && wd[9]) ? 1'b1 : (done[1] ? 1'b0 : mDbg);
    if (wr && addr == 1) begin
      mWkey = wd[3:0]; mTkey = wd[7:4]; mLock = wd[12]; mWen = wd[13];
    end
  endtask

  task automatic regChk(string tag);
    @(negedge clk);
    srcEvt = '0; cmdDone = '0; busSel = 1; busWr = 0; busAddr = 0;
    #1 chk(tag, busRdata, expStatus());
    busAddr = 1;
    #1 chk(tag, busRdata, expCtrl());
    chk(tag, {29'b0, warmRstEn, swRstCmd}, {29'b0, mWen, mDbg, mCore});
    busSel = 0;
  endtask

  function automatic logic [31:0] ctrlWord(logic [3:0] wk, logic [3:0] tk, logic [1:0] cmd,
                                           logic lk, logic we);
    return {18'b0, we, lk, 2'b0, cmd, tk, wk};
  endfunction

  task automatic doReset();
    @(negedge clk); rst_n = 0; srcEvt = '0; cmdDone = '0; busSel = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    doReset();
    // R1 reset state
    regChk("R1");
    chk("R1 ctrl value", expCtrl(), 32'h0000202A);
    // R2 latching and stickiness
    step("R2", 8'h03, 0, 0, 0, 0);
    step("R2", 8'h00, 0, 0, 0, 0);
    regChk("R2");
    // R3 clear one flag, zero write has no effect
    step("R3", 8'h00, 0, 1, 0, 32'h01);
    regChk("R3");
    step("R3", 8'h00, 0, 1, 0, 32'h00);
    regChk("R3");
    // R4 set beats clear
    step("R4", 8'h02, 0, 1, 0, 32'h02);
    regChk("R4");
    // R5 warm boot bit with zero flag bits
    step("R5", 8'h00, 0, 1, 0, 32'h10000);
    regChk("R5");
    // R6 default unmasked, then masked (R8), then undefined key
    step("R6", 8'h04, 0, 0, 0, 0);
    step("R6", 8'h00, 0, 1, 0, 32'h10004);
    step("R8", 8'h00, 0, 1, 1, ctrlWord(4'h5, 4'h2, 0, 0, 1));
    step("R8", 8'h04, 0, 0, 0, 0);
    step("R8", 8'h00, 0, 1, 0, 32'h04);
    regChk("R8");
    step("R6", 8'h00, 0, 1, 1, ctrlWord(4'h7, 4'h2, 0, 0, 1));
    step("R6", 8'h04, 0, 0, 0, 0);
    // R7 temperature key codes
    step("R7", 8'h00, 0, 1, 1, ctrlWord(4'hA, 4'h5, 0, 0, 1));
    step("R7", 8'h20, 0, 0, 0, 0);
    step("R7", 8'h00, 0, 1, 1, ctrlWord(4'hA, 4'hF, 0, 0, 1));
    step("R7", 8'h20, 0, 0, 0, 0);
    regChk("R7");
    // R9 lockup gating
    step("R9", 8'h40, 0, 0, 0, 0);
    step("R9", 8'h00, 0, 1, 1, ctrlWord(4'hA, 4'h2, 0, 1, 0));
    step("R9", 8'h40, 0, 0, 0, 0);
    regChk("R9");
    // R10 command bits
    step("R10", 8'h00, 0, 1, 1, ctrlWord(4'hA, 4'h2, 2'b01, 1, 0));
    regChk("R10");
    step("R10", 8'h00, 0, 1, 1, ctrlWord(4'hA, 4'h2, 2'b00, 1, 0));
    regChk("R10");
    step("R10", 8'h00, 2'b11, 1, 1, ctrlWord(4'hA, 4'h2, 2'b10, 1, 0));
    regChk("R10");
    step("R10", 8'h00, 2'b10, 0, 0, 0);
    regChk("R10");
    // R11 pass-through with everything masked
    step("R11", 8'h00, 0, 1, 1, ctrlWord(4'h5, 4'h5, 0, 0, 1));
    step("R11", 8'hFF, 0, 0, 0, 0);
    // R12 unmapped address
    step("R12", 8'h00, 0, 1, 4'h3, 32'hFFFF_FFFF);
    regChk("R12");
    @(negedge clk); busSel = 1; busWr = 0; busAddr = 4'h9;
    #1 chk("R12 read", busRdata, 32'h0);
    busSel = 0;
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] evt;
      logic [1:0] done;
      logic [31:0] wd;
      logic [3:0] addr, wk, tk;
      logic wr;
      evt  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      done = 2'($urandom) & 2'($urandom);
      wr   = ($urandom % 3) == 0;
      addr = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 2);
      case ($urandom % 4)
        0: wk = 4'h5; 1: wk = 4'hA; 2: wk = 4'h2; default: wk = 4'($urandom);
      endcase
      case ($urandom % 4)
        0: tk = 4'h5; 1: tk = 4'h2; 2: tk = 4'hA; default: tk = 4'($urandom);
      endcase
      wd = (addr == 1) ? ctrlWord(wk, tk, 2'($urandom), 1'($urandom), 1'($urandom))
                       : {15'b0, 1'($urandom), 8'b0, 8'($urandom) & 8'($urandom)};
      step("R6 R7 R9 R11", evt, done, wr, addr, wd);
      if (i % 8 == 7) regChk("R2 R3 R4 R5 R8 R10");
    end
    // R8 a locked watchdog flag clears only on hardware reset
    step("R8", 8'h00, 0, 1, 1, ctrlWord(4'h5, 4'h2, 0, 0, 1));
    step("R8", 8'h04, 0, 0, 0, 0);
    step("R8", 8'h00, 0, 1, 0, 32'hFF);
    regChk("R8");
    doReset();
    regChk("R8 R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule